// File: doc/BRIEF.md
# Programmable Clock and Tone Output Divider

This block drives one output pin with a square wave taken from one of two clocks: a fast main clock or a slow sub clock. An 8-bit control register sets three things: which source is used, a power-of-two division ratio, and whether the output is on. Software writes the register through a simple write strobe in the main clock domain. It can read the register back at any time.

Each source has its own free-running divider counter that runs on that source's clock. For the main clock the ratios are 1, 2, 4, 8 and 16, then jump to 2048, 4096 and 8192. For the sub clock the ratios run without gaps from 1 to 128. The enable is brought into the selected clock domain. It then opens or closes the output gate only while the divided clock is low, so starting or stopping never produces a shortened pulse.

A stop-mode input shuts off output from the main clock, because that clock halts in stop mode. Output from the sub clock keeps running. A low-power real-time-clock mode input blocks output from the sub clock and leaves main-clock output alone.

Top module: `clk_tone_gen`

## Requirements
- R1: After reset the register reads 0x00 and `toneOut` is low.
- R2: Register layout: bit 7 is the output enable, bit 3 selects the source (0 = main clock, 1 = sub clock), and bits 2:0 hold the ratio code. Bits 6:4 always read back as 0. When the output is disabled, a write stores bit 7 and bits 3:0 as written.
- R3: With the main source enabled, ratio codes 0 to 7 give an output period of 1, 2, 4, 8, 16, 2048, 4096 and 8192 main clock periods, with a 50% duty cycle.
- R4: With the sub source enabled, ratio code k gives an output period of 2^k sub clock periods (k = 0 to 7), with a 50% duty cycle.
- R5: While the stored enable bit is 1, a write leaves bits 3:0 unchanged; only bit 7 takes the written value.
- R6: While the enable bit is 0, `toneOut` stays low once the closing delay has passed (two synchronizer cycles plus up to half an output period).
- R7: While `stopMode` is 1, main-sourced output is held low. Sub-sourced output keeps its period even while the main clock is halted.
- R8: While `rtcLowPower` is 1, sub-sourced output is held low. Main-sourced output is not affected.
- R9: Every high pulse on `toneOut` is a full half period, including the first pulse after enabling. The output gate changes state only while the selected divided clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mainClk | input | 1 | Fast main clock; also clocks the register |
| subClk | input | 1 | Slow sub clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on mainClk |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value, bits 6:4 forced to 0 |
| stopMode | input | 1 | Stop-mode indication; blocks main-sourced output |
| rtcLowPower | input | 1 | Low-power real-time-clock mode; blocks sub-sourced output |
| toneOut | output | 1 | Divided and gated clock output |

## Verification
A wrong tap in either counter shows up on `toneOut` as a wrong period. The bench sees it within about three output periods, because it times each edge to the nanosecond against the expected ratio. A gate that opens or closes at the wrong point shows up as a short high pulse. The first pulse after enabling is measured for this, and the checker also flags it on the first gate change that falls outside the low phase. A wrong register write rule shows up at once in the read-back value. It also shows up as an unchanged or changed period after a write that should have been ignored.

// File: rtl/clk_tone_pkg.sv
package clk_tone_pkg;
  localparam int RatioW    = 3;
  localparam int CodeCount = 1 << RatioW;

  // Strobes and selections passed from the control to the datapath
  typedef struct packed {
    logic              outEn;
    logic              srcSub;
    logic [RatioW-1:0] ratio;
  } toneCtrl_t;
endpackage

// File: rtl/clk_tone_ctrl.sv
module clk_tone_ctrl
  import clk_tone_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int EN_BIT  = 7,
  parameter int SRC_BIT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output toneCtrl_t        ctrl
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (wrEn) begin
      ctrl.outEn <= wrData[EN_BIT];
      // selection is frozen while the output is running
      if (!ctrl.outEn) begin
        ctrl.srcSub <= wrData[SRC_BIT];
        ctrl.ratio  <= wrData[RatioW-1:0];
      end
    end
  end

  always_comb begin
    rdData                = '0;
    rdData[EN_BIT]        = ctrl.outEn;
    rdData[SRC_BIT]       = ctrl.srcSub;
    rdData[RatioW-1:0]    = ctrl.ratio;
  end
endmodule

// File: rtl/clk_tone_lane.sv
module clk_tone_lane
  import clk_tone_pkg::*;
#(
  parameter int FAST_CODES  = 5,
  parameter int SLOW_LOG2   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              rstN,
  input  logic              wantEn,
  input  logic [RatioW-1:0] ratio,
  output logic              gateOpen,
  output logic              quiet,
  output logic              laneOut
);
  localparam int CntW = (FAST_CODES >= CodeCount) ? CodeCount - 1
                                                  : SLOW_LOG2 + CodeCount - 1 - FAST_CODES;
  localparam int IdxW = (CntW > 1) ? $clog2(CntW) : 1;

  logic [CntW-1:0]        cnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [IdxW-1:0]        tapIdx;
  logic                   tapBit;

  function automatic int tapOf(input logic [RatioW-1:0] code);
    int c;
    int idx;
    c = int'(code);
    if (c < FAST_CODES) idx = c - 1;
    else                idx = SLOW_LOG2 - 1 + c - FAST_CODES;
    if (idx < 0)        idx = 0;
    if (idx > CntW - 1) idx = CntW - 1;
    return idx;
  endfunction

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], wantEn};
  end

  always_comb begin
    tapIdx = IdxW'(tapOf(ratio));
    tapBit = cnt[tapIdx];
    quiet  = (ratio == '0) || !tapBit;
  end

  // gate moves on the falling source edge, only in the divided low phase
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN)      gateOpen <= 1'b0;
    else if (quiet) gateOpen <= syncQ[SYNC_STAGES-1];
  end

  assign laneOut = ((ratio == '0) ? srcClk : tapBit) & gateOpen;
endmodule

// File: rtl/clk_tone_datapath.sv
module clk_tone_datapath
  import clk_tone_pkg::*;
#(
  parameter int MAIN_FAST_CODES = 5,
  parameter int MAIN_SLOW_LOG2  = 11,
  parameter int SUB_FAST_CODES  = 8,
  parameter int SUB_SLOW_LOG2   = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic      mainClk,
  input  logic      subClk,
  input  logic      rstN,
  input  toneCtrl_t ctrl,
  input  logic      stopMode,
  input  logic      rtcLowPower,
  output logic      toneOut,
  output logic      mainOut,
  output logic      subOut,
  output logic      mainGate,
  output logic      subGate,
  output logic      mainQuiet,
  output logic      subQuiet
);
  localparam int Lanes = 2;

  logic [Lanes-1:0] laneClk, laneWant, laneGate, laneQuiet, laneOut;

  assign laneClk  = {subClk, mainClk};
  assign laneWant = {ctrl.outEn &  ctrl.srcSub & !rtcLowPower,
                     ctrl.outEn & !ctrl.srcSub & !stopMode};

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    localparam int Fast = (g == 0) ? MAIN_FAST_CODES : SUB_FAST_CODES;
    localparam int Slow = (g == 0) ? MAIN_SLOW_LOG2  : SUB_SLOW_LOG2;
    clk_tone_lane #(
      .FAST_CODES (Fast),
      .SLOW_LOG2  (Slow),
      .SYNC_STAGES(SYNC_STAGES)
    ) uLane (
      .srcClk  (laneClk[g]),
      .rstN    (rstN),
      .wantEn  (laneWant[g]),
      .ratio   (ctrl.ratio),
      .gateOpen(laneGate[g]),
      .quiet   (laneQuiet[g]),
      .laneOut (laneOut[g])
    );
  end

  assign mainOut   = laneOut[0];
  assign subOut    = laneOut[1];
  assign mainGate  = laneGate[0];
  assign subGate   = laneGate[1];
  assign mainQuiet = laneQuiet[0];
  assign subQuiet  = laneQuiet[1];
  assign toneOut   = |laneOut;
endmodule

// File: rtl/clk_tone_gen.sv
module clk_tone_gen
  import clk_tone_pkg::*;
#(
  parameter int MAIN_FAST_CODES = 5,
  parameter int MAIN_SLOW_LOG2  = 11,
  parameter int SUB_FAST_CODES  = 8,
  parameter int SUB_SLOW_LOG2   = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       mainClk,
  input  logic       subClk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       stopMode,
  input  logic       rtcLowPower,
  output logic       toneOut
);
  toneCtrl_t ctrl;
  logic mainOut, subOut, mainGate, subGate, mainQuiet, subQuiet;

  clk_tone_ctrl #(.REG_W(8), .EN_BIT(7), .SRC_BIT(3)) uCtrl (
    .clk   (mainClk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrData(wrData),
    .rdData(rdData),
    .ctrl  (ctrl)
  );

  clk_tone_datapath #(
    .MAIN_FAST_CODES(MAIN_FAST_CODES),
    .MAIN_SLOW_LOG2 (MAIN_SLOW_LOG2),
    .SUB_FAST_CODES (SUB_FAST_CODES),
    .SUB_SLOW_LOG2  (SUB_SLOW_LOG2),
    .SYNC_STAGES    (SYNC_STAGES)
  ) uData (
    .mainClk    (mainClk),
    .subClk     (subClk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .stopMode   (stopMode),
    .rtcLowPower(rtcLowPower),
    .toneOut    (toneOut),
    .mainOut    (mainOut),
    .subOut     (subOut),
    .mainGate   (mainGate),
    .subGate    (subGate),
    .mainQuiet  (mainQuiet),
    .subQuiet   (subQuiet)
  );
endmodule

// File: rtl/clk_tone_checker.sv
module clk_tone_checker (
  input logic       mainClk,
  input logic       subClk,
  input logic       rstN,
  input logic [7:0] rdData,
  input logic       rtcLowPower,
  input logic       subOut,
  input logic       mainGate,
  input logic       subGate,
  input logic       mainQuiet,
  input logic       subQuiet
);
  // R2: reserved bits never read as one
  a_r2_reserved_zero: assert property (@(posedge mainClk) disable iff (!rstN)
    rdData[6:4] == 3'b000);

  // R5: selection holds while the output is enabled
  a_r5_select_locked: assert property (@(posedge mainClk) disable iff (!rstN)
    rdData[7] |=> rdData[3:0] == $past(rdData[3:0]));

  // R8: low-power mode held for several sub cycles keeps the sub lane quiet
  a_r8_rtc_blocks_sub: assert property (@(posedge subClk) disable iff (!rstN)
    (rtcLowPower && $past(rtcLowPower) && $past(rtcLowPower, 2) && $past(rtcLowPower, 3))
      |-> !subOut);

  // R9: main gate changes only during the divided low phase
  a_r9_main_gate_low: assert property (@(posedge mainClk) disable iff (!rstN)
    (mainGate != $past(mainGate)) |-> mainQuiet);

  // R9: sub gate changes only during the divided low phase
  a_r9_sub_gate_low: assert property (@(posedge subClk) disable iff (!rstN)
    (subGate != $past(subGate)) |-> subQuiet);
endmodule

bind clk_tone_gen clk_tone_checker uChk (
  .mainClk    (mainClk),
  .subClk     (subClk),
  .rstN       (rstN),
  .rdData     (rdData),
  .rtcLowPower(rtcLowPower),
  .subOut     (subOut),
  .mainGate   (mainGate),
  .subGate    (subGate),
  .mainQuiet  (mainQuiet),
  .subQuiet   (subQuiet)
);

// File: tb/clk_tone_gen_test.sv
`timescale 1ns/1ps
module clk_tone_gen_test;
  localparam real MainPer = 4.0;
  localparam real SubPer  = 40.0;

  logic       mainClk = 1'b0, subClk = 1'b0, rstN = 1'b0;
  logic       wrEn = 1'b0, stopMode = 1'b0, rtcLowPower = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       toneOut;
  logic       mainRun = 1'b1;
  int         checks = 0, fails = 0;

  clk_tone_gen uut (
    .mainClk(mainClk), .subClk(subClk), .rstN(rstN), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .stopMode(stopMode),
    .rtcLowPower(rtcLowPower), .toneOut(toneOut)
  );

  always begin #2; if (mainRun) mainClk = ~mainClk; end
  always begin #20; subClk = ~subClk; end

  function automatic real expPeriod(input bit sub, input int code);
    if (sub) return SubPer * real'(1 << code);
    if (code < 5) return MainPer * real'(1 << code);
    return MainPer * real'(1 << (code + 6));
  endfunction

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.1f expected=%0.1f", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge mainClk); wrEn = 1'b1; wrData = d;
    @(negedge mainClk); wrEn = 1'b0;
  endtask

  task automatic waitEdge(input bit level, input real maxNs, output real t, output bit ok);
    bit prev;
    real waited;
    prev = toneOut; waited = 0.0; ok = 1'b0; t = 0.0;
    while (waited < maxNs && !ok) begin
      #1; waited += 1.0;
      if (prev != level && toneOut == level) begin ok = 1'b1; t = $realtime; end
      prev = toneOut;
    end
  endtask

  // period and high width of the first full pulse seen
  task automatic checkFreq(input real expPer, input string req);
    real t0, t1, t2, lim;
    bit o0, o1, o2;
    #0.5;
    lim = 3.0 * expPer + 500.0;
    waitEdge(1'b1, lim, t0, o0);
    waitEdge(1'b0, lim, t1, o1);
    waitEdge(1'b1, lim, t2, o2);
    if (!(o0 && o1 && o2)) begin
      check(1'b0, req, -1.0, expPer);
      return;
    end
    check((t2 - t0) > expPer - 1.5 && (t2 - t0) < expPer + 1.5, req, t2 - t0, expPer);
    check((t1 - t0) > expPer / 2.0 - 1.5 && (t1 - t0) < expPer / 2.0 + 1.5,
          {req, " R9 high width"}, t1 - t0, expPer / 2.0);
  endtask

  task automatic expectOff(input real settleNs, input real windowNs, input string req);
    int highs;
    #(settleNs + 0.5);
    highs = 0;
    for (int i = 0; i < int'(windowNs); i++) begin
      #1; if (toneOut) highs++;
    end
    check(highs == 0, req, real'(highs), 0.0);
  endtask

  task automatic runCfg(input bit sub, input int code, input string req);
    real p;
    p = expPeriod(sub, code);
    wr({4'b0000, sub, 3'(code)});
    wr({4'b1000, sub, 3'(code)});
    checkFreq(p, req);
    wr({4'b0000, sub, 3'(code)});
    expectOff(p + 200.0, p + 100.0, "R6 disabled output low");
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(posedge mainClk);
    #1;
    check(rdData == 8'h00, "R1 reset register", real'(rdData), 0.0);
    check(toneOut == 1'b0, "R1 reset output", real'(toneOut), 0.0);
    @(negedge mainClk); rstN = 1'b1;

    // R2: random disabled writes read back with bits 6:4 cleared
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'($urandom) & 8'h7F;
      wr(d);
      check(rdData == (d & 8'h0F), "R2 readback", real'(rdData), real'(d & 8'h0F));
    end
    wr(8'h00);
    expectOff(50.0, 200.0, "R6 disabled after writes");

    // R3 main ratios, R4 sub ratios
    for (int c = 0; c < 8; c++) runCfg(1'b0, c, "R3 main period");
    for (int c = 0; c < 8; c++) runCfg(1'b1, c, "R4 sub period");

    // R5: selection writes ignored while enabled
    wr(8'h02); wr(8'h82);
    wr(8'h8B);
    check(rdData == 8'h82, "R5 locked while enabled", real'(rdData), real'(8'h82));
    checkFreq(expPeriod(1'b0, 2), "R5 period unchanged");
    wr(8'h0B);
    check(rdData == 8'h02, "R5 disable keeps selection", real'(rdData), real'(8'h02));
    expectOff(200.0, 200.0, "R6 off after locked write");

    // R8: low-power RTC mode blocks sub, leaves main
    wr(8'h08); wr(8'h88);
    checkFreq(expPeriod(1'b1, 0), "R8 sub before lowpower");
    rtcLowPower = 1'b1;
    expectOff(300.0, 400.0, "R8 sub blocked in lowpower");
    rtcLowPower = 1'b0;
    checkFreq(expPeriod(1'b1, 0), "R8 sub after lowpower");
    wr(8'h08);
    expectOff(300.0, 200.0, "R6 off before main");
    rtcLowPower = 1'b1;
    wr(8'h01); wr(8'h81);
    checkFreq(expPeriod(1'b0, 1), "R8 main unaffected");
    rtcLowPower = 1'b0;

    // R7: stop mode blocks main, sub survives halted main clock
    stopMode = 1'b1;
    expectOff(100.0, 200.0, "R7 main blocked in stop");
    stopMode = 1'b0;
    checkFreq(expPeriod(1'b0, 1), "R7 main after stop");
    wr(8'h01);
    expectOff(100.0, 100.0, "R6 off before sub stop");
    wr(8'h0A); wr(8'h8A);
    stopMode = 1'b1;
    @(negedge mainClk); mainRun = 1'b0;
    checkFreq(expPeriod(1'b1, 2), "R7 sub runs in stop");
    mainRun = 1'b1; stopMode = 1'b0;
    wr(8'h0A);
    expectOff(400.0, 200.0, "R6 off after stop");

    // random configurations
    for (int i = 0; i < 6; i++) begin
      bit sub;
      int code;
      sub  = 1'($urandom);
      code = sub ? int'($urandom % 8) : int'($urandom % 5);
      runCfg(sub, code, sub ? "R4 random sub" : "R3 random main");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule